// File: doc/BRIEF.md
# Aligned Periodic Tick Generator

This block turns a slow timebase, presented as a single-cycle strobe once per 32.768 kHz period, into a programmable periodic event. A 16-bit count advances on every strobe and never reloads. A tick happens when that count, just after it advances, is an exact multiple of the selected period. Because of this, ticks always fall on period boundaries of the shared count. After the rate code changes, the first tick comes at the next boundary of the new period, with no leftover partial interval from the old one.

Each tick produces a one-clock pulse and sets two sticky status flags: a periodic flag and an interrupt-request flag. The interrupt-request flag is also the interrupt line. Both flags stay set until software asserts the clear input. The rate code and the enable come straight from control register fields held elsewhere. They are sampled live, so any change takes effect from the next strobe.

Top module: `ptick_top`

## Requirements
- R1: The internal 16-bit count starts at 0 after reset and advances by exactly one on each cycle where `tb_strobe` is high. It wraps from 0xFFFF to 0x0000. Its value after an advance decides the tick, so a tick is due when the count wraps to 0.
- R2: No tick is produced while `per_en` is 0 or `rate_sel` is 0.
- R3: Rate codes 1 and 2 behave as codes 8 and 9, giving periods of 128 and 256 strobes.
- R4: For rate codes 3 through 15, the period is 2^(code-1) strobes: 4 strobes for code 3 and 16384 for code 15.
- R5: A strobe produces a tick when the count value after its advance has its low (effective code - 1) bits all zero. After a rate change, the next tick therefore lands on the next multiple of the new period.
- R6: `tick_pulse` is high for exactly the one clock cycle that follows a ticking strobe. It is never high in a cycle that does not follow a strobe.
- R7: On the same clock edge that raises `tick_pulse`, both `per_flag` and `req_flag` become 1.
- R8: The flags keep their value until `flag_clr` is high. A clear with no coinciding tick drives both flags to 0 one clock later.
- R9: When a tick and `flag_clr` fall in the same cycle, the tick wins and both flags are 1 afterwards.
- R10: While reset is active, and right after it, `tick_pulse`, `per_flag` and `req_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tb_strobe | input | 1 | One-cycle pulse for each 32.768 kHz timebase period |
| rate_sel | input | 4 | Rate code; 0 stops ticks |
| per_en | input | 1 | Periodic enable |
| flag_clr | input | 1 | Clears both status flags |
| tick_pulse | output | 1 | One-cycle pulse on each tick |
| per_flag | output | 1 | Sticky periodic flag |
| req_flag | output | 1 | Sticky interrupt-request flag, also the interrupt line |

## Verification
Every result is due exactly one clock after the edge that captures a strobe. On that edge the count advances, `tick_pulse` rises, and both flags are set. A clear shows up one clock after the edge that captures `flag_clr`. The driver updates inputs on the falling edge and queues one expected pulse value for each strobe it issues. The monitor reads the outputs one nanosecond after each rising edge and pops one entry for each captured strobe. On cycles with no strobe, it expects the pulse to be low. Flag checks after a clear or a collision are made on the falling edge that follows the capturing edge.

// File: rtl/ptick_pkg.sv
package ptick_pkg;
  localparam int CODE_W    = 4;
  localparam int ALIAS_MAX = 2;
  localparam int ALIAS_ADD = 7;

  typedef logic [CODE_W-1:0] rate_t;

  typedef struct packed {
    logic req;
    logic per;
  } flags_t;

  // Number of low count bits that must be zero for a tick.
  function automatic int tick_shift(input rate_t code);
    int eff;
    eff = (int'(code) <= ALIAS_MAX) ? int'(code) + ALIAS_ADD : int'(code);
    return eff - 1;
  endfunction
endpackage

// File: rtl/ptick_counter.sv
module ptick_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nxt
);
  assign cnt_nxt = cnt_q + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (strobe) cnt_q <= cnt_nxt;
  end

  a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));
  a_r1_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(cnt_q));
endmodule

// File: rtl/ptick_match.sv
module ptick_match
  import ptick_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  input  rate_t            rate,
  input  logic             en,
  input  logic [CNT_W-1:0] cnt_nxt,
  output logic             tick_set,
  output logic             tick_q
);
  logic [CNT_W-1:0] low_mask;
  int               shift;

  assign shift = tick_shift(rate);

  for (genvar g = 0; g < CNT_W; g++) begin : g_mask
    assign low_mask[g] = (g < shift);
  end

  assign tick_set = strobe && en && (rate != '0) && ((cnt_nxt & low_mask) == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) tick_q <= 1'b0;
    else        tick_q <= tick_set;
  end

  a_r6_pulse_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> !tick_q);
  a_r2_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (!en || rate == '0) |=> !tick_q);
endmodule

// File: rtl/ptick_flags.sv
module ptick_flags
  import ptick_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   set,
  input  logic   clr,
  output flags_t flags_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)   flags_q <= '0;
    else if (set) flags_q <= '{req: 1'b1, per: 1'b1};
    else if (clr) flags_q <= '0;
  end

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> (flags_q == '0));
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!set && !clr) |=> $stable(flags_q));
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set && clr) |=> (flags_q.per && flags_q.req));
endmodule

// File: rtl/ptick_top.sv
module ptick_top
  import ptick_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tb_strobe,
  input  logic [CODE_W-1:0] rate_sel,
  input  logic              per_en,
  input  logic              flag_clr,
  output logic              tick_pulse,
  output logic              per_flag,
  output logic              req_flag
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             tick_set;
  flags_t           flags_q;

  ptick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .strobe(tb_strobe),
    .cnt_q(cnt_q), .cnt_nxt(cnt_nxt)
  );

  ptick_match #(.CNT_W(CNT_W)) u_match (
    .clk(clk), .rst_n(rst_n), .strobe(tb_strobe), .rate(rate_sel),
    .en(per_en), .cnt_nxt(cnt_nxt), .tick_set(tick_set), .tick_q(tick_pulse)
  );

  ptick_flags u_flags (
    .clk(clk), .rst_n(rst_n), .set(tick_set), .clr(flag_clr), .flags_q(flags_q)
  );

  assign per_flag = flags_q.per;
  assign req_flag = flags_q.req;

  a_r7_pulse_flags: assert property (@(posedge clk) disable iff (!rst_n)
    tick_pulse |-> (per_flag && req_flag));
  a_r5_aligned_count: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_pulse && rate_sel == 4'd3 && $stable(rate_sel)) |-> (cnt_q[1:0] == 2'b00));
endmodule

// File: tb/tb_ptick_top.sv
`timescale 1ns/1ps
module tb_ptick_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tb_strobe = 1'b0;
  logic [3:0] rate_sel = 4'd0;
  logic       per_en = 1'b0;
  logic       flag_clr = 1'b0;
  logic       tick_pulse, per_flag, req_flag;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  logic [15:0] mdl_cnt = 16'd0;
  bit    exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  ptick_top dut (
    .clk(clk), .rst_n(rst_n), .tb_strobe(tb_strobe), .rate_sel(rate_sel),
    .per_en(per_en), .flag_clr(flag_clr), .tick_pulse(tick_pulse),
    .per_flag(per_flag), .req_flag(req_flag)
  );

  function automatic bit model_tick(input logic [15:0] nc);
    int eff;
    logic [15:0] m;
    if (!per_en || rate_sel == 4'd0) return 1'b0;
    eff = (rate_sel <= 4'd2) ? int'(rate_sel) + 7 : int'(rate_sel);
    m = 16'((32'd1 << (eff - 1)) - 1);
    return (nc & m) == 16'd0;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // Driver: one strobe per call item, expected pulse pushed per strobe.
  task automatic drive(input int n, input int gap, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tb_strobe = 1'b1;
      mdl_cnt = mdl_cnt + 16'd1;
      exp_q.push_back(model_tick(mdl_cnt));
      tag_q.push_back(req);
      for (int k = 0; k < gap; k++) begin
        @(negedge clk);
        tb_strobe = 1'b0;
      end
    end
    @(negedge clk);
    tb_strobe = 1'b0;
  endtask

  // Monitor: one expected item per captured strobe.
  always @(posedge clk) begin
    logic cap;
    cap = tb_strobe;
    #1;
    if (rst_n && !finished) begin
      if (cap && exp_q.size() > 0) begin
        bit e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, tick_pulse, e);
        if (e) begin
          check("R7 per_flag", per_flag, 1'b1);
          check("R7 req_flag", req_flag, 1'b1);
        end
      end else begin
        check("R6 no strobe", tick_pulse, 1'b0);
      end
    end
  end

  task automatic do_clear();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 tick_pulse", tick_pulse, 1'b0);
    check("R10 per_flag", per_flag, 1'b0);
    check("R10 req_flag", req_flag, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 per_flag after", per_flag, 1'b0);

    rate_sel = 4'd3; per_en = 1'b0;
    drive(20, 0, "R2 enable low");
    rate_sel = 4'd0; per_en = 1'b1;
    drive(20, 0, "R2 code zero");
    check("R2 flags untouched", per_flag, 1'b0);

    rate_sel = 4'd3;
    drive(40, 0, "R4 code 3");
    check("R7 per_flag sticky", per_flag, 1'b1);
    do_clear();
    check("R8 per_flag cleared", per_flag, 1'b0);
    check("R8 req_flag cleared", req_flag, 1'b0);

    drive(13, 2, "R6 gapped strobes");
    rate_sel = 4'd5;
    drive(70, 0, "R5 rate change");
    rate_sel = 4'd4;
    drive(3, 0, "R5 rate change again");
    drive(30, 1, "R4 code 4");
    rate_sel = 4'd1;
    drive(300, 0, "R3 code 1 as 8");
    rate_sel = 4'd2;
    drive(600, 0, "R3 code 2 as 9");

    // R9: tick coinciding with clear
    rate_sel = 4'd3;
    do_clear();
    while (!model_tick(mdl_cnt + 16'd1)) drive(1, 0, "R9 approach");
    @(negedge clk);
    tb_strobe = 1'b1; flag_clr = 1'b1;
    mdl_cnt = mdl_cnt + 16'd1;
    exp_q.push_back(1'b1); tag_q.push_back("R9 collision pulse");
    @(negedge clk);
    tb_strobe = 1'b0; flag_clr = 1'b0;
    check("R9 per_flag kept", per_flag, 1'b1);
    check("R9 req_flag kept", req_flag, 1'b1);

    // R1: wrap of the count with the longest period
    rate_sel = 4'd15;
    drive(65536 - int'(mdl_cnt) + 20, 0, "R1 wrap code 15");
    check("R1 wrapped", (mdl_cnt < 16'd100), 1'b1);
    rate_sel = 4'd3;
    drive(16, 0, "R5 after wrap");

    repeat (3) @(negedge clk);
    summary();
  end
endmodule